// File: doc/BRIEF.md
# Per-Port Power Control Sequencer

This block is the state machine that one output port of a multi-port power-sourcing controller instantiates. A master sequencer visits the ports one after another and lends the selected port the shared measurement converter and the shared ramp engine. While the port holds that grant, this block walks it through three steps. First it checks the load's signature. Then it checks the load's class. If both are acceptable, it ramps up power. Once the port is powered, each later visit takes a load-current reading and decides whether the load is still attached.

The signature, class and load-current checks are done outside the block and arrive as single-bit flags. Each flag is qualified by the converter's completion strobe. A registered `done` pulse tells the master sequencer that it may move on. The `port_active` output lets the master skip ports that have nothing to do. An overcurrent indication removes power in the same cycle, whatever the grant or state. It then leaves a fault flag set, and the port stays off until software clears the flag.

Top module: `port_power_seq`

## Requirements
- R1: After reset `pwr_en`, `done` and `fault` are 0, and with both command bits 0 `port_active` is 0.
- R2: With no fault, `port_active` is 1 while the port is idle only if `cmd_enable`=1 and `cmd_disable`=0, and it is always 1 while a sequence is in progress or the port is powered. While `fault`=1, `port_active` is 0.
- R3: While `sel`=0 no state change happens: strobes are ignored, `done` stays 0 and `pwr_en` keeps its value. The only exception is an overcurrent on a powered port.
- R4: A selected, idle, enabled port with no fault starts detection at the next edge. A converter strobe with `det_ok`=0 returns it to idle, with `done`=1 for one cycle after that edge and power off.
- R5: After a good detection, a converter strobe with `cls_ok`=1 raises `pwr_en` at that edge. With `cls_ok`=0 the port returns to idle with a `done` pulse and power off.
- R6: While the port is ramping, `ramp_done` produces a `done` pulse and power stays on.
- R7: `cmd_disable`=1 on a powered port has no effect until the port is next selected. At that edge power goes off and `done` pulses.
- R8: On each selection of a powered port, the first edge starts a measurement. The converter strobe then pulses `done`, and power stays on if `load_present`=1 or goes off if it is 0.
- R9: `oc_flag`=1 on a powered port forces `pwr_en` to 0 combinationally, in any state and whether or not the port is selected. At the next edge the port returns to idle.
- R10: An overcurrent on a powered port sets `fault` at the next edge. `fault` stays set until `fault_clr`=1. While `fault` is set, a selected, enabled port does not start: it pulses `done` and stays unpowered.
- R11: `done` is a one-cycle pulse and appears only in the cycle after an edge at which `sel` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Grant from the master sequencer |
| cmd_enable | input | 1 | Command bit: bring the port up |
| cmd_disable | input | 1 | Command bit: turn the port off / keep it off |
| fault_clr | input | 1 | Clears the latched fault flag |
| adc_done | input | 1 | Converter completion strobe |
| ramp_done | input | 1 | Ramp engine completion strobe |
| det_ok | input | 1 | Signature check passed |
| cls_ok | input | 1 | Class check passed |
| load_present | input | 1 | Load current above the disconnect level |
| oc_flag | input | 1 | Overcurrent indication |
| pwr_en | output | 1 | Port power switch enable |
| port_active | output | 1 | Status to master: port needs a visit |
| done | output | 1 | Status to master: this visit is finished |
| fault | output | 1 | Latched overcurrent fault |

## Verification
A wrong state register shows up at the ports within one selected edge. If the port sits in the wrong phase, a strobe produces a `done` pulse where none is due, or withholds one where it is due. It can also flip `pwr_en` at the wrong edge. The bench sweeps every combination of detection, class and load outcomes. It holds strobes while the grant is low to expose state that moves without the grant, and it injects overcurrent in every powered phase, with and without the grant. A missed overcurrent is caught in the same cycle, because `pwr_en` is checked before the next edge.

// File: rtl/port_power_seq.sv
module port_power_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic fault_clr,
  input  logic adc_done,
  input  logic ramp_done,
  input  logic det_ok,
  input  logic cls_ok,
  input  logic load_present,
  input  logic oc_flag,
  output logic pwr_en,
  output logic port_active,
  output logic done,
  output logic fault
);

  typedef enum logic [2:0] {
    S_IDLE, S_DETECT, S_CLASSIFY, S_RAMP, S_ON, S_MEAS
  } state_t;

  state_t state;
  logic   pwr_q;
  logic   start_ok;
  logic   oc_trip;

  assign pwr_q       = (state == S_RAMP) || (state == S_ON) || (state == S_MEAS);
  assign pwr_en      = pwr_q && !oc_flag;
  assign oc_trip     = oc_flag && pwr_q;
  assign start_ok    = cmd_enable && !cmd_disable && !fault;
  assign port_active = !fault && (start_ok || (state != S_IDLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fault_clr) fault <= 1'b0;
      if (oc_trip) begin
        state <= S_IDLE;
        fault <= 1'b1;
      end else if (sel) begin
        case (state)
          S_IDLE:
            if (start_ok) state <= S_DETECT;
            else          done  <= 1'b1;
          S_DETECT:
            if (adc_done) begin
              if (det_ok) state <= S_CLASSIFY;
              else begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
            end
          S_CLASSIFY:
            if (adc_done) begin
              if (cls_ok) state <= S_RAMP;
              else begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
            end
          S_RAMP:
            if (ramp_done) begin
              state <= S_ON;
              done  <= 1'b1;
            end
          S_ON:
            if (cmd_disable) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state <= S_MEAS;
            end
          S_MEAS:
            if (adc_done) begin
              state <= load_present ? S_ON : S_IDLE;
              done  <= 1'b1;
            end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_hold_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && !oc_trip |=> $stable(state));

  assert_power_after_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> $past(state == S_CLASSIFY && sel && adc_done && cls_ok));

  assert_disable_on_visit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel && state == S_ON && cmd_disable && !oc_flag |=> !pwr_q && done);

  assert_oc_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> fault && !pwr_q);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !fault_clr |=> fault);

  assert_fault_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !pwr_en);

  assert_done_needs_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sel));

endmodule

// File: tb/port_power_seq_bench.sv
module port_power_seq_bench;
  logic clk = 0, rst_n = 0;
  logic sel = 0, cmd_enable = 0, cmd_disable = 0, fault_clr = 0;
  logic adc_done = 0, ramp_done = 0, det_ok = 0, cls_ok = 0, load_present = 0, oc_flag = 0;
  logic pwr_en, port_active, done, fault;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  port_power_seq u_port_power_seq (.*);

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic bring_up(input logic d, input logic c);
    sel = 1; cmd_enable = 1; tick;
    chk("R4 start no done", done, 0);
    adc_done = 1; det_ok = d; tick; adc_done = 0;
    chk("R4 detect done", done, !d);
    chk("R4 detect pwr", pwr_en, 0);
    if (!d) begin sel = 0; tick; chk("R11 pulse", done, 0); return; end
    adc_done = 1; cls_ok = c; tick; adc_done = 0;
    chk("R5 class pwr", pwr_en, c);
    chk("R5 class done", done, !c);
    if (!c) begin sel = 0; tick; return; end
    ramp_done = 1; tick; ramp_done = 0;
    chk("R6 ramp done", done, 1);
    chk("R6 ramp pwr", pwr_en, 1);
    sel = 0; tick;
    chk("R11 one cycle", done, 0);
    chk("R6 stays on", pwr_en, 1);
  endtask

  task automatic turn_off;
    cmd_disable = 1; sel = 1; tick; sel = 0; cmd_disable = 0; tick;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk("R1 pwr", pwr_en, 0); chk("R1 done", done, 0);
    chk("R1 fault", fault, 0); chk("R1 active", port_active, 0);
    #20 rst_n = 1; tick;
    chk("R1 pwr after", pwr_en, 0);

    for (int e = 0; e < 2; e++)
      for (int x = 0; x < 2; x++) begin
        cmd_enable = e[0]; cmd_disable = x[0]; #1;
        chk("R2 idle active", port_active, e[0] & !x[0]);
      end
    cmd_enable = 0; cmd_disable = 0;
    sel = 1; tick; chk("R4 idle disabled visit done", done, 1);
    chk("R4 idle disabled no pwr", pwr_en, 0);
    sel = 0; tick;

    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++) begin
          bring_up(d[0], c[0]);
          if (d[0] & c[0]) begin
            cmd_enable = 0; #1;
            chk("R2 powered active", port_active, 1);
            sel = 1; tick;
            chk("R8 measure start", done, 0);
            adc_done = 1; load_present = l[0]; tick; adc_done = 0;
            chk("R8 measure done", done, 1);
            chk("R8 load kept", pwr_en, l[0]);
            sel = 0; tick;
            if (l[0]) begin
              cmd_disable = 1;
              for (int k = 0; k < 3; k++) begin
                tick; chk("R7 waits for visit", pwr_en, 1);
                chk("R3 no done", done, 0);
              end
              sel = 1; tick;
              chk("R7 off at visit", pwr_en, 0);
              chk("R7 done", done, 1);
              sel = 0; cmd_disable = 0; tick;
            end
          end else begin
            chk("R5 no pwr", pwr_en, 0);
          end
        end

    cmd_enable = 1; sel = 1; tick;
    sel = 0; adc_done = 1; det_ok = 1; cls_ok = 0; tick; tick;
    chk("R3 strobe ignored done", done, 0);
    chk("R3 strobe ignored pwr", pwr_en, 0);
    sel = 1; tick; adc_done = 0;
    chk("R3 still detecting", done, 0);
    adc_done = 1; cls_ok = 1; tick; adc_done = 0;
    chk("R3 then class", pwr_en, 1);
    sel = 0; ramp_done = 1; tick; tick; ramp_done = 0;
    chk("R3 ramp ignored", done, 0);
    sel = 1; ramp_done = 1; tick; ramp_done = 0; sel = 0;
    chk("R6 ramp on visit", done, 1);
    tick;
    turn_off();
    chk("R7 cleanup", pwr_en, 0);

    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 2; s++) begin
        cmd_enable = 1; sel = 1; tick;
        adc_done = 1; det_ok = 1; tick; cls_ok = 1; tick; adc_done = 0;
        if (p >= 1) begin ramp_done = 1; tick; ramp_done = 0; end
        sel = 0; tick;
        if (p == 2) begin sel = 1; tick; end
        sel = s[0]; #1;
        chk("R9 powered before oc", pwr_en, 1);
        oc_flag = 1; #1;
        chk("R9 immediate off", pwr_en, 0);
        tick; oc_flag = 0; sel = 0; #1;
        chk("R10 fault set", fault, 1);
        chk("R10 inactive", port_active, 0);
        tick; tick;
        chk("R9 stays off", pwr_en, 0);
        sel = 1; tick;
        chk("R10 no restart done", done, 1);
        chk("R10 no restart pwr", pwr_en, 0);
        sel = 0; tick;
        chk("R10 still fault", fault, 1);
        fault_clr = 1; tick; fault_clr = 0;
        chk("R10 cleared", fault, 0);
        chk("R2 active after clear", port_active, 1);
      end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule